// File: doc/BRIEF.md
# Replaying FIFO with Half-Full Flag

This block is a single-clock first-in/first-out buffer for 9-bit words. Writes and reads each step their own circular pointer, so the user never supplies an address. Reads and writes may occur in the same cycle. A read returns its word one cycle later, registered and marked by a one-cycle valid pulse.

Three active-low status flags report the buffer state: empty, full and half-full. Each flag is worked out from the distance between the write pointer and the read pointer. A write into a full buffer is dropped, and so is a read from an empty one.

An active-low rewind input sends the read pointer back to the first location without touching the write pointer. Everything written since reset can then be read out again, and all three flags follow the new pointer distance. A rewind is taken only in a cycle with no read or write request. A rewind that arrives together with a request is dropped and reported on a one-cycle error pulse.

Top module: `replay_fifo`

## Requirements
- R1: Words are read out in the order they were written. The word for a read accepted at a clock edge appears on rd_data after that edge, with rd_valid high for that cycle only. rd_valid is low in cycles that follow no accepted read.
- R2: A write and a read requested in the same cycle on a buffer that is neither empty nor full are both accepted, and the occupancy is unchanged.
- R3: full_n is low (0) exactly when the buffer holds DEPTH words. While it is low, a write request is ignored: the stored contents and the occupancy do not change. A read accepted from a full buffer raises full_n after the edge.
- R4: empty_n is low (0) exactly when the buffer holds no words. While it is low, a read request is ignored and rd_valid stays low. A write into an empty buffer raises empty_n after the edge, including when a read is requested in the same cycle.
- R5: While rst_n is low at a clock edge, both pointers go to the first location. Afterwards empty_n is 0, full_n is 1, half_n is 1, rd_valid is 0 and rewind_err is 0, and earlier contents cannot be read.
- R6: half_n is low (0) exactly when the occupancy exceeds DEPTH/2. It falls on the write that makes the occupancy DEPTH/2+1 and rises on the read that brings it back to DEPTH/2.
- R7: When rewind_n is 0 at an edge and neither wr_req nor rd_req is high, the read pointer goes to the first location and the write pointer keeps its value. The words written since reset can then be read again in order, and all flags follow the new occupancy.
- R8: When rewind_n is 0 at an edge while wr_req or rd_req is high, the rewind is ignored and the request proceeds normally. rewind_err is 1 for the following cycle only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_req | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| rd_req | input | 1 | Read request |
| rewind_n | input | 1 | Rewind the read pointer to the first location, active low |
| rd_data | output | WIDTH | Registered read word |
| rd_valid | output | 1 | One-cycle pulse marking rd_data |
| empty_n | output | 1 | Empty flag, active low |
| full_n | output | 1 | Full flag, active low |
| half_n | output | 1 | More than half full, active low |
| rewind_err | output | 1 | One-cycle pulse: rewind ignored because a request was active |

## Verification
A short table of single-cycle operations covers these cases:
- lone writes and lone reads;
- a read and a write in the same cycle on a partly filled buffer, which shows that both are accepted;
- a read and a write in the same cycle on an empty buffer, which shows that only the write is accepted;
- a rewind alongside a read, against a rewind on an idle cycle.

Filling the buffer step by step shows where the half-full and full boundaries sit. A write at full whose value must never come out shows that overflow is blocked. A full drain checked against a reference queue shows that wrap-around keeps the order. Writing and draining a block, then rewinding, shows that the half-full flag is worked out again after a rewind and that the replayed words match the originals.

// File: rtl/replay_fifo.sv
module replay_fifo #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_req,
  input  logic             rewind_n,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             empty_n,
  output logic             full_n,
  output logic             half_n,
  output logic             rewind_err
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr, occ;
  logic             wr_go, rd_go, idle, rew_go;

  assign occ     = wr_ptr - rd_ptr;
  assign empty_n = (occ != '0);
  assign full_n  = (occ != PW'(DEPTH));
  assign half_n  = !(occ > PW'(DEPTH / 2));

  assign wr_go  = wr_req && full_n;
  assign rd_go  = rd_req && empty_n;
  assign idle   = !wr_req && !rd_req;
  assign rew_go = !rewind_n && idle;

  always_ff @(posedge clk) begin
    if (wr_go) mem[wr_ptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      rd_data    <= '0;
      rd_valid   <= 1'b0;
      rewind_err <= 1'b0;
    end else begin
      if (wr_go) wr_ptr <= wr_ptr + 1'b1;
      if (rew_go) rd_ptr <= {wr_ptr[AW], {AW{1'b0}}};
      else if (rd_go) rd_ptr <= rd_ptr + 1'b1;
      if (rd_go) rd_data <= mem[rd_ptr[AW-1:0]];
      rd_valid   <= rd_go;
      rewind_err <= !rewind_n && !idle;
    end
  end
endmodule

// File: rtl/replay_fifo_chk.sv
module replay_fifo_chk #(
  parameter int AW = 9,
  parameter int PW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_req,
  input logic          rd_req,
  input logic          rewind_n,
  input logic          rd_valid,
  input logic          empty_n,
  input logic          full_n,
  input logic          half_n,
  input logic          rewind_err,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] rd_ptr
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && wr_req) |=> $stable(wr_ptr)); // R3
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!empty_n && !full_n)); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |=> !rd_valid); // R4
  AST_VALID_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(empty_n && rd_req)); // R1
  AST_HALF_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> !half_n); // R6
  AST_REWIND_KEEPS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (!rewind_n && !wr_req && !rd_req) |=> ($stable(wr_ptr) && rd_ptr[AW-1:0] == '0)); // R7
  AST_REWIND_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rewind_err |-> $past(!rewind_n && (wr_req || rd_req))); // R8
endmodule

bind replay_fifo replay_fifo_chk #(.AW(AW), .PW(PW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req), .rewind_n(rewind_n),
  .rd_valid(rd_valid), .empty_n(empty_n), .full_n(full_n), .half_n(half_n),
  .rewind_err(rewind_err), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
);

// File: tb/replay_fifo_tb_top.sv
`timescale 1ns/1ps
module replay_fifo_tb_top;
  localparam int DEPTH = 512;
  localparam int W = 9;

  logic clk = 1'b0, rst_n = 1'b0, wr_req = 1'b0, rd_req = 1'b0, rewind_n = 1'b1;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic rd_valid, empty_n, full_n, half_n, rewind_err;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [W-1:0] model [$];

  always #4 clk = ~clk;

  replay_fifo #(.DEPTH(DEPTH), .WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_data(wr_data), .rd_req(rd_req),
    .rewind_n(rewind_n), .rd_data(rd_data), .rd_valid(rd_valid), .empty_n(empty_n),
    .full_n(full_n), .half_n(half_n), .rewind_err(rewind_err)
  );

  // {wr, rd, rewind_n, din[8:0], exp_valid, exp_dout[8:0], exp_empty_n, exp_full_n, exp_half_n, exp_err}
  localparam logic [25:0] VEC [11] = '{
    {1'b1, 1'b0, 1'b1, 9'h1A5, 1'b0, 9'h000, 1'b1, 1'b1, 1'b1, 1'b0},
    {1'b1, 1'b0, 1'b1, 9'h05A, 1'b0, 9'h000, 1'b1, 1'b1, 1'b1, 1'b0},
    {1'b0, 1'b1, 1'b1, 9'h000, 1'b1, 9'h1A5, 1'b1, 1'b1, 1'b1, 1'b0},
    {1'b1, 1'b1, 1'b1, 9'h123, 1'b1, 9'h05A, 1'b1, 1'b1, 1'b1, 1'b0},
    {1'b0, 1'b1, 1'b1, 9'h000, 1'b1, 9'h123, 1'b0, 1'b1, 1'b1, 1'b0},
    {1'b0, 1'b1, 1'b1, 9'h000, 1'b0, 9'h000, 1'b0, 1'b1, 1'b1, 1'b0},
    {1'b1, 1'b1, 1'b1, 9'h0FF, 1'b0, 9'h000, 1'b1, 1'b1, 1'b1, 1'b0},
    {1'b0, 1'b1, 1'b0, 9'h000, 1'b1, 9'h0FF, 1'b0, 1'b1, 1'b1, 1'b1},
    {1'b0, 1'b0, 1'b0, 9'h000, 1'b0, 9'h000, 1'b1, 1'b1, 1'b1, 1'b0},
    {1'b0, 1'b1, 1'b1, 9'h000, 1'b1, 9'h1A5, 1'b1, 1'b1, 1'b1, 1'b0},
    {1'b0, 1'b1, 1'b1, 9'h000, 1'b1, 9'h05A, 1'b1, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic r, input logic rw_n, input logic [W-1:0] d);
    @(negedge clk);
    wr_req = w; rd_req = r; rewind_n = rw_n; wr_data = d;
    @(posedge clk);
    #1;
    wr_req = 1'b0; rd_req = 1'b0; rewind_n = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    @(negedge clk);
    rst_n = 1'b1;
    model.delete();
  endtask

  task automatic push(input logic [W-1:0] d);
    step(1'b1, 1'b0, 1'b1, d);
    model.push_back(d);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int bad;
    logic [W-1:0] e;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    #1;
    chk(!empty_n && full_n && half_n && !rd_valid && !rewind_err, "R5 reset state",
        {empty_n, full_n, half_n, rd_valid, rewind_err}, 5'b01100);

    foreach (VEC[i]) begin
      logic [25:0] v;
      v = VEC[i];
      step(v[25], v[24], v[23], v[22:14]);
      chk(rd_valid == v[13] && (!v[13] || rd_data == v[12:4]) && empty_n == v[3] &&
          full_n == v[2] && half_n == v[1] && rewind_err == v[0],
          $sformatf("R1 R2 R4 R7 R8 table step %0d", i),
          {rd_valid, rd_data, empty_n, full_n, half_n, rewind_err},
          {v[13], (v[13] ? v[12:4] : rd_data), v[3:0]});
    end

    do_reset();
    for (int k = 0; k < DEPTH / 2; k++) push(W'(k * 37 + 5));
    chk(half_n == 1'b1, "R6 half_n at DEPTH/2", half_n, 1);
    push(9'h155);
    chk(half_n == 1'b0, "R6 half_n at DEPTH/2+1", half_n, 0);
    step(1'b0, 1'b1, 1'b1, '0);
    e = model.pop_front();
    chk(rd_valid && rd_data == e && half_n, "R6 R1 read back to DEPTH/2", {rd_valid, rd_data, half_n}, {1'b1, e, 1'b1});
    while (model.size() < DEPTH) push(W'(model.size() * 11 + 3));
    chk(!full_n && empty_n, "R3 full_n low at DEPTH", {full_n, empty_n}, 2'b01);
    step(1'b1, 1'b0, 1'b1, 9'h1FF);
    chk(!full_n && !rd_valid, "R3 write at full ignored", {full_n, rd_valid}, 2'b00);
    step(1'b1, 1'b1, 1'b1, 9'h1FE);
    e = model.pop_front();
    chk(rd_valid && rd_data == e && full_n, "R3 read at full, write dropped", {rd_valid, rd_data, full_n}, {1'b1, e, 1'b1});
    bad = 0;
    while (model.size() > 0) begin
      step(1'b0, 1'b1, 1'b1, '0);
      e = model.pop_front();
      if (!rd_valid || rd_data != e) bad++;
    end
    chk(bad == 0, "R1 R3 drain order after wrap, dropped words absent", bad, 0);
    chk(!empty_n && half_n && full_n, "R4 empty after drain", {empty_n, half_n, full_n}, 3'b011);
    step(1'b0, 1'b1, 1'b1, '0);
    chk(!rd_valid && !empty_n, "R4 read at empty ignored", {rd_valid, empty_n}, 2'b00);

    push(9'h011); push(9'h022); push(9'h033);
    do_reset();
    #1;
    chk(!empty_n && full_n && half_n && !rd_valid, "R5 reset mid-use", {empty_n, full_n, half_n, rd_valid}, 4'b0110);
    step(1'b0, 1'b1, 1'b1, '0);
    chk(!rd_valid, "R5 old contents unreadable", rd_valid, 0);

    for (int k = 0; k < 300; k++) push(W'(k * 13 + 1));
    for (int k = 0; k < 300; k++) step(1'b0, 1'b1, 1'b1, '0);
    chk(!empty_n && half_n, "R4 empty after partial block read", {empty_n, half_n}, 2'b01);
    step(1'b0, 1'b0, 1'b0, '0);
    chk(empty_n && !half_n && full_n && !rewind_err, "R7 flags after idle rewind",
        {empty_n, half_n, full_n, rewind_err}, 4'b1010);
    bad = 0;
    for (int k = 0; k < 300; k++) begin
      step(1'b0, 1'b1, 1'b1, '0);
      if (!rd_valid || rd_data != model[k]) bad++;
    end
    chk(bad == 0, "R7 replay matches written words", bad, 0);
    chk(!empty_n, "R7 empty after replay", empty_n, 0);

    step(1'b1, 1'b0, 1'b0, 9'h0AB);
    chk(rewind_err && empty_n, "R8 rewind with write ignored, err pulse", {rewind_err, empty_n}, 2'b11);
    step(1'b0, 1'b0, 1'b1, '0);
    chk(!rewind_err, "R8 err lasts one cycle", rewind_err, 0);
    step(1'b0, 1'b1, 1'b1, '0);
    chk(rd_valid && rd_data == 9'h0AB && !empty_n, "R8 R1 write kept, read pointer not rewound",
        {rd_valid, rd_data, empty_n}, {1'b1, 9'h0AB, 1'b0});
    step(1'b0, 1'b0, 1'b1, '0);
    chk(!rd_valid, "R1 valid is a single pulse", rd_valid, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule